// File: doc/BRIEF.md
# Execute-Stage Group Arbiter with Fetch Redirect Selection

This block sits at the end of an out-of-order execute stage. Each cycle it receives one issued group of up to `IW` slots, with the results of execution already attached: a squashed flag, a mispredict flag with its predicted direction, a memory-ordering violation flag reported by the load/store queue, and the sequence number, PC and computed target of each slot. It scans the group in slot order. Instructions that are not squashed each take one functional unit. At most `EXEC_W` may execute per group, and every instruction the scan accepts goes on to commit.

In the same scan the block selects at most one fetch redirect for the group. The redirect is either a branch misprediction or a memory-order violation, and it produces a squash record for the front end. The block also raises per-slot strobes that wake dependents and mark destination registers ready. It keeps three event counters: squashed instructions passed through, mispredicted branches that had been predicted taken, and violation redirects. Every output is registered and describes the group presented in the previous cycle.

Top module: `exec_redirect_arb`

## Requirements
- R1: The scan stops at the first slot whose valid bit is 0. That slot and every later slot are not forwarded, even if their valid bits are 1.
- R2: The scan stops once `EXEC_W` non-squashed instructions have been accepted. Later slots, squashed or not, are not forwarded and cannot cause a redirect.
- R3: A squashed slot reached by the scan is forwarded to commit (`commit_o` bit set), uses no functional unit and cannot redirect. `cnt_sqexe_o` grows by the number of such slots.
- R4: Only the first non-squashed accepted slot with a mispredict or violation flag produces a redirect. If that slot has both flags, the mispredict wins.
- R5: A mispredict redirect sets `sq_vld_o`=1, `sq_misp_o`=1 and `viol_o`=0. It sets `sq_seq_o`, `sq_mispc_o` and `sq_npc_o` to the slot's sequence number, PC and target. `sq_taken_o`=1 exactly when the target differs from PC+4.
- R6: A violation redirect sets `sq_vld_o`=1, `viol_o`=1, `sq_seq_o` to the slot's sequence number and `sq_npc_o` to its target. `sq_mispc_o`, `sq_misp_o` and `sq_taken_o` are all 0.
- R7: `wake_o` bit i is 1 exactly when slot i was forwarded and is not squashed. Its population never exceeds `EXEC_W`.
- R8: All outputs reflect the group of the previous cycle only. A group with no redirect drives every squash-record field to 0.
- R9: `cnt_ptkn_o` grows by one for each mispredict redirect whose slot had its predicted-taken bit set. `cnt_viol_o` grows by one for each violation redirect.
- R10: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slot_vld_i | input | IW | Slot holds an instruction |
| slot_sq_i | input | IW | Slot instruction is squashed |
| slot_misp_i | input | IW | Slot branch was mispredicted |
| slot_ptkn_i | input | IW | Slot branch had been predicted taken |
| slot_viol_i | input | IW | Load/store queue reports an ordering violation for slot |
| slot_seq_i | input | IW*SW | Sequence numbers, slot i at bits [i*SW +: SW] |
| slot_pc_i | input | IW*PW | PCs, slot i at bits [i*PW +: PW] |
| slot_tgt_i | input | IW*PW | Computed targets, slot i at bits [i*PW +: PW] |
| commit_o | output | IW | Slot forwarded to commit (marked executed) |
| wake_o | output | IW | Wake dependents / mark destination ready |
| sq_vld_o | output | 1 | Squash request |
| sq_seq_o | output | SW | Squashing sequence number |
| sq_mispc_o | output | PW | Mispredicted PC |
| sq_npc_o | output | PW | Redirect PC |
| sq_misp_o | output | 1 | Redirect is a branch mispredict |
| sq_taken_o | output | 1 | Actual branch direction was taken |
| viol_o | output | 1 | Violation notify to instruction queue |
| cnt_sqexe_o | output | CW | Squashed pass-through count |
| cnt_ptkn_o | output | CW | Predicted-taken mispredict count |
| cnt_viol_o | output | CW | Violation redirect count |

## Verification
A wrong functional-unit count or a stuck scan flag appears on the very next cycle. It shows up as a `commit_o` mask that is too long or too short, or as a redirect taken from a slot the scan should never reach. A stale "redirect already taken" decision shows up as a squash record naming a later slot, or the wrong redirect kind. Errors in the counters accumulate and stay visible on later cycles, so comparing every cycle against the reference catches each error in the cycle it first appears.

// File: rtl/exec_redirect_arb.sv
`timescale 1ns/1ps
module exec_redirect_arb #(
  parameter int IW     = 4,
  parameter int EXEC_W = 2,
  parameter int SW     = 8,
  parameter int PW     = 32,
  parameter int CW     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IW-1:0]    slot_vld_i,
  input  logic [IW-1:0]    slot_sq_i,
  input  logic [IW-1:0]    slot_misp_i,
  input  logic [IW-1:0]    slot_ptkn_i,
  input  logic [IW-1:0]    slot_viol_i,
  input  logic [IW*SW-1:0] slot_seq_i,
  input  logic [IW*PW-1:0] slot_pc_i,
  input  logic [IW*PW-1:0] slot_tgt_i,
  output logic [IW-1:0]    commit_o,
  output logic [IW-1:0]    wake_o,
  output logic             sq_vld_o,
  output logic [SW-1:0]    sq_seq_o,
  output logic [PW-1:0]    sq_mispc_o,
  output logic [PW-1:0]    sq_npc_o,
  output logic             sq_misp_o,
  output logic             sq_taken_o,
  output logic             viol_o,
  output logic [CW-1:0]    cnt_sqexe_o,
  output logic [CW-1:0]    cnt_ptkn_o,
  output logic [CW-1:0]    cnt_viol_o
);
  localparam int FW = $clog2(IW + 1);
  localparam logic [FW-1:0] FU_MAX = FW'(EXEC_W);

  logic [IW-1:0] n_commit, n_wake;
  logic [FW-1:0] fu, n_sqn;
  logic          run, n_red, n_br, n_tkn, n_ptw;
  logic [SW-1:0] n_seq;
  logic [PW-1:0] n_pc, n_npc, pc_i, tgt_i;

  always_comb begin
    n_commit = '0; n_wake = '0; n_sqn = '0; fu = '0; run = 1'b1;
    n_red = 1'b0; n_br = 1'b0; n_tkn = 1'b0; n_ptw = 1'b0;
    n_seq = '0; n_pc = '0; n_npc = '0; pc_i = '0; tgt_i = '0;
    for (int i = 0; i < IW; i++) begin
      if (run && (fu == FU_MAX || !slot_vld_i[i])) run = 1'b0;
      if (run) begin
        n_commit[i] = 1'b1;
        if (slot_sq_i[i]) begin
          n_sqn = n_sqn + 1'b1;
        end else begin
          fu = fu + 1'b1;
          n_wake[i] = 1'b1;
          if (!n_red && (slot_misp_i[i] || slot_viol_i[i])) begin
            pc_i  = slot_pc_i[i*PW +: PW];
            tgt_i = slot_tgt_i[i*PW +: PW];
            n_red = 1'b1;
            n_br  = slot_misp_i[i];
            n_seq = slot_seq_i[i*SW +: SW];
            n_npc = tgt_i;
            n_pc  = slot_misp_i[i] ? pc_i : '0;
            n_tkn = slot_misp_i[i] && (tgt_i != pc_i + PW'(4));
            n_ptw = slot_misp_i[i] && slot_ptkn_i[i];
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      commit_o <= '0; wake_o <= '0;
      sq_vld_o <= 1'b0; sq_seq_o <= '0; sq_mispc_o <= '0; sq_npc_o <= '0;
      sq_misp_o <= 1'b0; sq_taken_o <= 1'b0; viol_o <= 1'b0;
      cnt_sqexe_o <= '0; cnt_ptkn_o <= '0; cnt_viol_o <= '0;
    end else begin
      commit_o   <= n_commit;
      wake_o     <= n_wake;
      sq_vld_o   <= n_red;
      sq_seq_o   <= n_seq;
      sq_mispc_o <= n_pc;
      sq_npc_o   <= n_npc;
      sq_misp_o  <= n_br;
      sq_taken_o <= n_tkn;
      viol_o     <= n_red && !n_br;
      cnt_sqexe_o <= cnt_sqexe_o + CW'(n_sqn);
      if (n_ptw) cnt_ptkn_o <= cnt_ptkn_o + 1'b1;
      if (n_red && !n_br) cnt_viol_o <= cnt_viol_o + 1'b1;
    end
  end

  assert_prefix_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ((commit_o + 1'b1) & commit_o) == '0);
  assert_fu_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wake_o) <= EXEC_W);
  assert_one_kind_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sq_vld_o |-> $onehot({sq_misp_o, viol_o}));
  assert_taken_branch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sq_taken_o |-> sq_misp_o && sq_vld_o);
  assert_viol_fields_R6: assert property (@(posedge clk) disable iff (!rst_n)
    viol_o |-> sq_vld_o && sq_mispc_o == '0);
  assert_wake_sub_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_o & ~commit_o) == '0);
  assert_redirect_needs_exec_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sq_vld_o |-> wake_o != '0);
endmodule

// File: tb/exec_redirect_arb_tb_top.sv
`timescale 1ns/1ps
module exec_redirect_arb_tb_top;
  localparam int IW = 4, EW = 2, SW = 8, PW = 32, CW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [IW-1:0] vld, sq, misp, ptkn, viol;
  logic [IW*SW-1:0] seq;
  logic [IW*PW-1:0] pc, tgt;
  logic [IW-1:0] commit_o, wake_o;
  logic sq_vld_o, sq_misp_o, sq_taken_o, viol_o;
  logic [SW-1:0] sq_seq_o;
  logic [PW-1:0] sq_mispc_o, sq_npc_o;
  logic [CW-1:0] cnt_sqexe_o, cnt_ptkn_o, cnt_viol_o;

  int checks = 0, fails = 0;
  logic [IW-1:0] e_commit, e_wake;
  logic e_red, e_br, e_tkn;
  logic [SW-1:0] e_seq;
  logic [PW-1:0] e_pc, e_npc;
  int e_sqcnt = 0, e_ptcnt = 0, e_vcnt = 0;

  always #2.5 clk = ~clk;

  exec_redirect_arb #(.IW(IW), .EXEC_W(EW), .SW(SW), .PW(PW), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .slot_vld_i(vld), .slot_sq_i(sq), .slot_misp_i(misp),
    .slot_ptkn_i(ptkn), .slot_viol_i(viol), .slot_seq_i(seq), .slot_pc_i(pc),
    .slot_tgt_i(tgt), .commit_o(commit_o), .wake_o(wake_o), .sq_vld_o(sq_vld_o),
    .sq_seq_o(sq_seq_o), .sq_mispc_o(sq_mispc_o), .sq_npc_o(sq_npc_o),
    .sq_misp_o(sq_misp_o), .sq_taken_o(sq_taken_o), .viol_o(viol_o),
    .cnt_sqexe_o(cnt_sqexe_o), .cnt_ptkn_o(cnt_ptkn_o), .cnt_viol_o(cnt_viol_o));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic clear_grp();
    vld = '0; sq = '0; misp = '0; ptkn = '0; viol = '0; seq = '0; pc = '0; tgt = '0;
  endtask

  task automatic put(input int i, input bit v, input bit s, input bit m, input bit p,
                     input bit x, input int sn, input logic [PW-1:0] a, input logic [PW-1:0] t);
    vld[i] = v; sq[i] = s; misp[i] = m; ptkn[i] = p; viol[i] = x;
    seq[i*SW +: SW] = SW'(sn); pc[i*PW +: PW] = a; tgt[i*PW +: PW] = t;
  endtask

  task automatic model();
    int fu = 0;
    e_commit = '0; e_wake = '0; e_red = 0; e_br = 0; e_tkn = 0;
    e_seq = '0; e_pc = '0; e_npc = '0;
    for (int i = 0; i < IW; i++) begin
      if (fu >= EW || !vld[i]) break;
      e_commit[i] = 1;
      if (sq[i]) begin e_sqcnt++; continue; end
      fu++;
      e_wake[i] = 1;
      if (!e_red && misp[i]) begin
        e_red = 1; e_br = 1; e_seq = seq[i*SW +: SW];
        e_pc = pc[i*PW +: PW]; e_npc = tgt[i*PW +: PW];
        e_tkn = (tgt[i*PW +: PW] != pc[i*PW +: PW] + 32'd4);
        if (ptkn[i]) e_ptcnt++;
      end else if (!e_red && viol[i]) begin
        e_red = 1; e_seq = seq[i*SW +: SW]; e_npc = tgt[i*PW +: PW];
        e_vcnt++;
      end
    end
  endtask

  task automatic step_and_compare();
    model();
    @(negedge clk);
    chk("R1/R2/R3 commit", 64'(commit_o), 64'(e_commit));
    chk("R7 wake", 64'(wake_o), 64'(e_wake));
    chk("R4/R8 sq_vld", 64'(sq_vld_o), 64'(e_red));
    chk("R5/R6 sq_seq", 64'(sq_seq_o), 64'(e_seq));
    chk("R5/R6 sq_mispc", 64'(sq_mispc_o), 64'(e_pc));
    chk("R5/R6 sq_npc", 64'(sq_npc_o), 64'(e_npc));
    chk("R4/R5 sq_misp", 64'(sq_misp_o), 64'(e_br));
    chk("R5 sq_taken", 64'(sq_taken_o), 64'(e_tkn));
    chk("R6 viol", 64'(viol_o), 64'(e_red && !e_br));
    chk("R3 cnt_sqexe", 64'(cnt_sqexe_o), 64'(CW'(e_sqcnt)));
    chk("R9 cnt_ptkn", 64'(cnt_ptkn_o), 64'(CW'(e_ptcnt)));
    chk("R9 cnt_viol", 64'(cnt_viol_o), 64'(CW'(e_vcnt)));
  endtask

  initial begin
    #(5.0 * 100000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    clear_grp();
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 reset commit", 64'(commit_o), 0);
    chk("R10 reset sq_vld", 64'(sq_vld_o), 0);
    chk("R10 reset counters", 64'({cnt_sqexe_o, cnt_ptkn_o, cnt_viol_o}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 empty group
    clear_grp(); step_and_compare();
    // R3 all squashed, all forwarded
    clear_grp(); for (int i = 0; i < IW; i++) put(i, 1, 1, 1, 0, 1, i, 32'h100, 32'h200);
    step_and_compare();
    // R4 violation slot first, mispredict later
    clear_grp(); put(0, 1, 0, 0, 0, 1, 7, 32'h40, 32'h44); put(1, 1, 0, 1, 1, 0, 8, 32'h48, 32'h80);
    step_and_compare();
    // R4 both flags on one slot: mispredict wins; R5 taken
    clear_grp(); put(0, 1, 0, 1, 1, 1, 9, 32'h1000, 32'h2000); step_and_compare();
    // R5 not taken: target = pc+4
    clear_grp(); put(0, 1, 0, 1, 0, 0, 10, 32'h1000, 32'h1004); step_and_compare();
    // R2 third non-squashed slot beyond EXEC_W, mispredict ignored
    clear_grp(); put(0, 1, 0, 0, 0, 0, 1, 0, 0); put(1, 1, 0, 0, 0, 0, 2, 0, 0);
    put(2, 1, 0, 1, 1, 0, 3, 32'h30, 32'h90); step_and_compare();
    // R1 gap stops scan
    clear_grp(); put(0, 1, 0, 0, 0, 0, 1, 0, 0); put(1, 0, 0, 0, 0, 0, 0, 0, 0);
    put(2, 1, 0, 1, 0, 0, 5, 32'h8, 32'h20); step_and_compare();
    // R3/R6 squashed mispredict skipped, later violation taken
    clear_grp(); put(0, 1, 1, 1, 1, 0, 4, 32'h10, 32'h50); put(1, 1, 0, 0, 0, 1, 6, 32'h14, 32'h14);
    step_and_compare();
    // R8 quiet group clears record
    clear_grp(); put(0, 1, 0, 0, 0, 0, 1, 0, 0); step_and_compare();
    for (int n = 0; n < 2000; n++) begin
      clear_grp();
      for (int i = 0; i < IW; i++)
        put(i, ($urandom % 8) != 0, ($urandom % 3) == 0, ($urandom % 4) == 0,
            $urandom % 2, ($urandom % 5) == 0, $urandom % 256,
            {$urandom % 64, 2'b00}, ($urandom % 2) ? {$urandom % 64, 2'b00} + 32'd4
                                                   : {$urandom % 64, 2'b00});
      step_and_compare();
    end
    report();
  end
endmodule